// File: doc/BRIEF.md
# Autobaud Start-Bit Calibrator

This block sits beside a serial receiver and sets its baud-rate divisor from the line itself. Software arms it by writing a one to the arm bit while the receive line is idle. The next falling edge on the line opens a measurement window. The block then counts system clocks until the line returns high. At the end of the window it turns the count into a divisor for a 16x oversampling baud generator and presents that divisor with a one-cycle load strobe.

The arm bit is self-clearing. It drops in the same cycle as the load strobe, or in the same cycle as an error pulse when the measurement cannot yield a usable divisor. A single start bit gives the whole calibration. The receive line is brought in through a two-flop synchronizer before any edge is detected. Decoding of the characters that follow is left to the receiver.

Top module: `abd_calib`

## Requirements
- R1: After reset, `armed` is 0, `div_out` is 0, and both `div_load` and `err_pulse` are 0.
- R2: A write (`arm_wr`=1) with `arm_val`=1 is accepted when the block is disarmed and the synchronized line is high. In that case `armed` reads 1 from the next cycle.
- R3: An arm write made while the synchronized line is low is ignored, and `armed` stays 0. A start bit that follows produces neither a load nor an error.
- R4: A write with `arm_val`=0 disarms the block. A start bit that follows produces no load.
- R5: When armed, the block counts N, the number of clocks the synchronized line stays low after its first falling edge. It then loads `div_out` = floor((N+8)/16) - 1, which is the count over 16 rounded to nearest, minus one. The load is marked by `div_load` high for exactly one cycle.
- R6: `armed` falls in the same cycle that `div_load` is high. Later start bits leave `div_out` unchanged and raise no `div_load` until the block is armed again.
- R7: If floor((N+8)/16) is 1 or less (N < 24), the resulting divisor would be zero. In that case `err_pulse` is high for one cycle, `armed` clears, no load occurs, and `div_out` keeps its previous value.
- R8: If the line stays low beyond 2^CNT_W - 1 clocks (4095 with the default CNT_W=12), the block raises `err_pulse` for one cycle, clears `armed`, and does not load.
- R9: A falling edge on the line while the block is disarmed produces neither `div_load` nor `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Receive line, asynchronous, idle high |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_val | input | 1 | Value written to the arm bit |
| div_out | output | CNT_W-4 | Most recently measured baud divisor |
| div_load | output | 1 | One-cycle strobe when `div_out` takes a new value |
| err_pulse | output | 1 | One-cycle strobe on a failed measurement |
| armed | output | 1 | Live state of the arm bit |

## Verification
The bench goes after the rounding edge between 167 and 168 clocks. A design that truncates instead of rounding would load 9 at 168 instead of 10. It also probes the smallest legal width (24 versus 23 clocks) and the exact counter limit (4095 loads 255, 4096 errors). An off-by-one in the count or in the overflow compare shows up there as a wrong divisor or a missing error. Arming while the line is low, and start bits sent after a calibration or after a disarm, catch a design that fails to gate the arm write or to clear itself. Error cases check that the old divisor survives.

// File: rtl/abd_pkg.sv
package abd_pkg;

    // log2 of the receiver oversampling rate
    localparam int OVS_LOG2 = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEAS = 2'd2
    } abd_state_e;

    // end-of-window events from the meter
    typedef struct packed {
        logic done;  // line returned high, count valid
        logic ovf;   // counter limit reached with line still low
    } meas_evt_t;

    // arm-bit write as seen by the controller
    typedef struct packed {
        logic set_req;
        logic clr_req;
    } arm_req_t;

    function automatic arm_req_t decode_arm(input logic wr, input logic val);
        arm_req_t r;
        r.set_req = wr & val;
        r.clr_req = wr & ~val;
        return r;
    endfunction

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    output logic rx_s,
    output logic rx_fall
);
    logic [STAGES-1:0] chain;
    logic              rx_prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= rx_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rx_prev <= 1'b1;
        else     rx_prev <= chain[STAGES-1];
    end

    assign rx_s    = chain[STAGES-1];
    assign rx_fall = rx_prev & ~chain[STAGES-1];

endmodule

// File: rtl/abd_meter.sv
module abd_meter
    import abd_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rx_s,
    output meas_evt_t        evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        evt.done = busy & rx_s;
        evt.ovf  = busy & ~rx_s & (cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
        end else if (busy) begin
            if (evt.done || evt.ovf) busy <= 1'b0;
            else                     cnt  <= cnt + 1'b1;
        end
    end

    assign count = cnt;

    // R8: the count never wraps to zero inside a window
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !evt.done && !evt.ovf) |=> (cnt != '0));

    // R5: the end of a window releases the meter
    a_r5_done_releases: assert property (@(posedge clk) disable iff (rst)
        (evt.done && !start) |=> !busy);

endmodule

// File: rtl/abd_divcalc.sv
module abd_divcalc
    import abd_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]          count,
    output logic [CNT_W-OVS_LOG2-1:0] div,
    output logic                      too_small
);
    localparam int Q_W = CNT_W + 1 - OVS_LOG2;
    localparam logic [CNT_W:0] HALF = (CNT_W+1)'(1 << (OVS_LOG2 - 1));

    logic [CNT_W:0] sum;
    logic [Q_W-1:0] quo;
    logic [Q_W-1:0] quo_m1;

    always_comb begin
        sum       = {1'b0, count} + HALF;
        quo       = sum[CNT_W:OVS_LOG2];
        quo_m1    = quo - Q_W'(1);
        too_small = (quo <= Q_W'(1));
        div       = quo_m1[CNT_W-OVS_LOG2-1:0];
    end

endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
    import abd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_wr,
    input  logic             arm_val,
    input  logic             rx_s,
    input  logic             rx_fall,
    input  meas_evt_t        evt,
    input  logic [DIV_W-1:0] div_calc,
    input  logic             too_small,
    output logic             meas_start,
    output logic [DIV_W-1:0] div_q,
    output logic             load_q,
    output logic             err_q,
    output logic             armed
);
    abd_state_e st;
    arm_req_t   req;

    always_comb begin
        req        = decode_arm(arm_wr, arm_val);
        meas_start = (st == ST_WAIT) && rx_fall && !req.clr_req;
        armed      = (st != ST_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_OFF;
            div_q  <= '0;
            load_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            load_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st)
                ST_OFF: begin
                    if (req.set_req && rx_s) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (req.clr_req)  st <= ST_OFF;
                    else if (rx_fall) st <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (req.clr_req) begin
                        st <= ST_OFF;
                    end else if (evt.done) begin
                        st <= ST_OFF;
                        if (too_small) begin
                            err_q <= 1'b1;
                        end else begin
                            load_q <= 1'b1;
                            div_q  <= div_calc;
                        end
                    end else if (evt.ovf) begin
                        st    <= ST_OFF;
                        err_q <= 1'b1;
                    end
                end
                default: st <= ST_OFF;
            endcase
        end
    end

    // R6: a load always coincides with the bit clearing
    a_r6_load_disarms: assert property (@(posedge clk) disable iff (rst)
        load_q |-> !armed);

    // R7/R8: an error also clears the bit, and never coincides with a load
    a_r7_err_disarms: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (!armed && !load_q));

    // R2/R3: arming only follows an accepted write on an idle line
    a_r3_arm_only_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(arm_wr && arm_val && rx_s));

    // R7: divisor only changes on a load, and a loaded value is never zero
    a_r7_div_stable: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> load_q);
    a_r7_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        load_q |-> (div_q != '0));

endmodule

// File: rtl/abd_calib.sv
module abd_calib
    import abd_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int SYNC_STGS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_in,
    input  logic                      arm_wr,
    input  logic                      arm_val,
    output logic [CNT_W-OVS_LOG2-1:0] div_out,
    output logic                      div_load,
    output logic                      err_pulse,
    output logic                      armed
);
    localparam int DIV_W = CNT_W - OVS_LOG2;

    logic             rx_s;
    logic             rx_fall;
    logic             meas_start;
    meas_evt_t        evt;
    logic [CNT_W-1:0] count;
    logic [DIV_W-1:0] div_calc;
    logic             too_small;

    abd_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rx_raw  (rx_in),
        .rx_s    (rx_s),
        .rx_fall (rx_fall)
    );

    abd_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .start (meas_start),
        .rx_s  (rx_s),
        .evt   (evt),
        .count (count)
    );

    abd_divcalc #(.CNT_W(CNT_W)) u_divcalc (
        .count     (count),
        .div       (div_calc),
        .too_small (too_small)
    );

    abd_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm_wr     (arm_wr),
        .arm_val    (arm_val),
        .rx_s       (rx_s),
        .rx_fall    (rx_fall),
        .evt        (evt),
        .div_calc   (div_calc),
        .too_small  (too_small),
        .meas_start (meas_start),
        .div_q      (div_out),
        .load_q     (div_load),
        .err_q      (err_pulse),
        .armed      (armed)
    );

    // R9: nothing is reported while the block is idle and disarmed
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        ($past(!armed) && !armed) |-> (!div_load && !err_pulse));

endmodule

// File: tb/abd_calib_tb.sv
module abd_calib_tb;

    localparam int CNT_W = 12;
    localparam int DIV_W = CNT_W - 4;
    localparam int NV    = 9;

    // stimulus: low width in clocks; expected: error flag, divisor after
    localparam int VLEN [NV] = '{160, 23, 167, 168, 24, 1000, 4096, 4095, 1};
    localparam int VERR [NV] = '{0,   1,  0,   0,   0,  0,    1,    0,    1};
    localparam int VDIV [NV] = '{9,   9,  9,   10,  1,  62,   62,   255,  255};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_in = 1'b1;
    logic arm_wr = 1'b0;
    logic arm_val = 1'b0;
    logic [DIV_W-1:0] div_out;
    logic div_load, err_pulse, armed;

    int checks = 0;
    int failures = 0;
    int n_load = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    abd_calib #(.CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .rx_in     (rx_in),
        .arm_wr    (arm_wr),
        .arm_val   (arm_val),
        .div_out   (div_out),
        .div_load  (div_load),
        .err_pulse (err_pulse),
        .armed     (armed)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst && div_load)  n_load = n_load + 1;
        if (!rst && err_pulse) n_err  = n_err + 1;
        if (cyc > 150000 && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual cyc=%0d expected < 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arm_write(input logic v);
        @(negedge clk);
        arm_wr  = 1'b1;
        arm_val = v;
        @(negedge clk);
        arm_wr  = 1'b0;
        arm_val = 1'b0;
    endtask

    task automatic low_pulse(input int n);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (n) @(negedge clk);
        rx_in = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        int l0, e0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 armed", armed, 0);
        check("R1 div_out", div_out, 0);
        check("R1 div_load", div_load, 0);
        check("R1 err_pulse", err_pulse, 0);

        // R9 start bit while disarmed
        low_pulse(160);
        check("R9 no load", n_load, 0);
        check("R9 no err", n_err, 0);

        // vector table: R2 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            l0 = n_load;
            e0 = n_err;
            arm_write(1'b1);
            check("R2 armed after write", armed, 1);
            low_pulse(VLEN[i]);
            check("R5/R7/R8 load count", n_load - l0, 1 - VERR[i]);
            check("R7/R8 err count", n_err - e0, VERR[i]);
            check("R5/R7 div_out", div_out, VDIV[i]);
            check("R6 armed cleared", armed, 0);
        end

        // R6 second start bit after a calibration has no effect
        arm_write(1'b1);
        low_pulse(320);
        check("R6 calibrated div", div_out, 19);
        l0 = n_load;
        low_pulse(168);
        check("R6 no reload", n_load - l0, 0);
        check("R6 div kept", div_out, 19);

        // R3 arm write while line is low is ignored
        @(negedge clk);
        rx_in = 1'b0;
        repeat (5) @(negedge clk);
        arm_write(1'b1);
        check("R3 armed stays 0", armed, 0);
        l0 = n_load;
        e0 = n_err;
        rx_in = 1'b1;
        repeat (8) @(negedge clk);
        low_pulse(168);
        check("R3 no load", n_load - l0, 0);
        check("R3 no err", n_err - e0, 0);
        check("R3 div kept", div_out, 19);

        // R4 disarm by writing 0
        arm_write(1'b1);
        check("R4 armed before clear", armed, 1);
        arm_write(1'b0);
        check("R4 armed after clear", armed, 0);
        l0 = n_load;
        low_pulse(168);
        check("R4 no load", n_load - l0, 0);
        check("R4 div kept", div_out, 19);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule